// File: doc/BRIEF.md
# Scheduled Serial Avionics Word Transmitter

This block is one transmit channel for ARINC 429 style serial words. A small register file holds a one-byte control value, an entry count and a table of 32-bit words. While the run bit is set, a sequencer walks the table from entry 0 up to the entry count. A serializer sends each word as return-to-zero pulses on a pair of outputs, HI for a one and LO for a zero. These outputs feed an external differential line driver.

After each pass through the table the channel has two options. It can start the next pass at once, or it can hold until an external repetition counter sends a one-cycle tick. Two bit rates are available, with a ratio of eight between them. The last transmitted bit may be replaced by a computed parity bit. Clearing the run bit never cuts a word short. Setting it again always starts over at the first table entry.

Top module: `a429_tx_channel`

## Requirements
- R1: All control bits reset to 0. All eight bits, including the unused bits 2..0, are plain storage and read back unchanged on `ctrl_rd`. Bit fields: 7 run, 6 slow rate, 5 parity enable, 4 parity sense, 3 wait-for-tick.
- R2: When run (bit 7) is 0, no new word starts. A word already in flight finishes, including its null gap, and then the outputs stay low.
- R3: When run goes from 0 to 1, the first word sent is table entry 0. This also holds if run is cleared and set again while a word is in flight: that word finishes, and entry 0 follows.
- R4: When bit 6 is 0, each half bit cell lasts `HALF_HI` clocks. When bit 6 is 1, each half lasts `HALF_HI*LO_RATIO` clocks. The rate is sampled when a word starts and holds for the whole word.
- R5: When bit 5 is 1, the 32nd word bit (data bit 31) is replaced so that the count of ones over all 32 bits is even if bit 4 is 1, or odd if bit 4 is 0. When bit 5 is 0, data bit 31 is sent as stored.
- R6: When a pass ends and bit 3 is 1, the channel waits for the next `rep_tick` pulse that arrives after the pass ends, then restarts at entry 0. Ticks that arrive earlier are ignored. When bit 3 is 0, entry 0 follows after only the normal null gap.
- R7: Each bit is sent return-to-zero. A 1 raises `tx_hi` and a 0 raises `tx_lo` for the first half of the bit cell. Both are low in the second half, and the two are never high together.
- R8: Between consecutive words, both outputs stay low for at least `NULL_BITS` bit cells after the last bit cell ends.
- R9: Word bits 1..8 (data[7:0]) go first, most significant first: data[7] down to data[0]. Data[8] through data[31] follow in ascending order.
- R10: A pass sends entries 0 to count-1. A count of 0 sends nothing while run is set. A count write above `DEPTH` is stored as `DEPTH`.
- R11: A write with `wr_tbl`=1 loads table entry `wr_idx`. With `wr_tbl`=0, `wr_idx`=0 loads the control byte from `wr_data[7:0]` and `wr_idx`=1 loads the entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_tbl | input | 1 | 1 selects the word table, 0 selects control/count |
| wr_idx | input | $clog2(DEPTH) | Table entry, or 0 = control, 1 = count |
| wr_data | input | 32 | Write data |
| rep_tick | input | 1 | One-cycle repetition counter rollover pulse |
| tx_hi | output | 1 | Line driver HI input |
| tx_lo | output | 1 | Line driver LO input |
| ctrl_rd | output | 8 | Control byte readback |

## Verification
A write reaches `ctrl_rd` one clock after the strobe. The first pulse of a word starts one clock after the sequencer issues it. Every pulse and every in-word low phase then lasts exactly one half cell at the rate latched for that word. The bench decodes the line at the falling clock edge. It rebuilds each word from pulse starts and measures every pulse width and low interval in clocks, so it never depends on when the first word begins. Checks that something must not happen (no extra word after a stop, no pass before a tick, nothing with a zero count) wait longer than one full low-rate word plus its gap before the decoded word count is compared.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEND,
        S_BUSY,
        S_HOLD
    } seq_state_e;

    // Build the on-line bit sequence: element k is the k-th bit sent.
    function automatic logic [31:0] line_order(
        input logic [31:0] data,
        input logic        par_en,
        input logic        par_even
    );
        logic [31:0] w;
        logic [31:0] s;
        w = data;
        if (par_en) begin
            w[31] = par_even ? (^data[30:0]) : ~(^data[30:0]);
        end
        for (int i = 0; i < 8; i++) begin
            s[i] = w[7-i];
        end
        for (int i = 8; i < 32; i++) begin
            s[i] = w[i];
        end
        return s;
    endfunction

endpackage

// File: rtl/a429_tx_regs.sv
module a429_tx_regs #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       ctrl,
    output logic [CNT_W-1:0] count,
    output logic [31:0]      rd_word
);

    typedef struct packed {
        logic [7:0]                  ctrl;
        logic [CNT_W-1:0]            cnt;
        logic [DEPTH-1:0][31:0]      tbl;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_tbl) begin
                d.tbl[wr_idx] = wr_data;
            end else if (wr_idx == IDX_W'(0)) begin
                d.ctrl = wr_data[7:0];
            end else if (wr_idx == IDX_W'(1)) begin
                if (wr_data > 32'(DEPTH)) begin
                    d.cnt = CNT_W'(DEPTH);
                end else begin
                    d.cnt = wr_data[CNT_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctrl    = q.ctrl;
    assign count   = q.cnt;
    assign rd_word = q.tbl[rd_idx];

    p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));

    p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
    import a429_tx_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             skip,
    input  logic [CNT_W-1:0] count,
    input  logic [31:0]      rd_word,
    input  logic             ser_done,
    input  logic             rep_tick,
    output logic [IDX_W-1:0] rd_idx,
    output logic             start,
    output logic [31:0]      start_word,
    output logic             start_slow
);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             run_prev;
        logic             restart;
    } seq_t;

    seq_t q, d;
    logic             rise;
    logic [CNT_W-1:0] idx_ext;
    logic [CNT_W-1:0] nxt_ext;

    always_comb begin
        d          = q;
        start      = 1'b0;
        rise       = run && !q.run_prev;
        d.run_prev = run;
        idx_ext    = CNT_W'(q.idx);
        nxt_ext    = idx_ext + CNT_W'(1);
        case (q.st)
            S_IDLE: begin
                if (run) begin
                    d.idx     = '0;
                    d.restart = 1'b0;
                    d.st      = S_SEND;
                end
            end
            S_SEND: begin
                if (!run) begin
                    d.st = S_IDLE;
                end else if (count == '0) begin
                    d.st = S_SEND;
                end else if (idx_ext >= count) begin
                    d.idx = '0;
                    d.st  = skip ? S_HOLD : S_SEND;
                end else begin
                    start = 1'b1;
                    d.st  = S_BUSY;
                end
            end
            S_BUSY: begin
                if (rise) begin
                    d.restart = 1'b1;
                end
                if (ser_done) begin
                    if (!run) begin
                        d.restart = 1'b0;
                        d.st      = S_IDLE;
                    end else if (q.restart || rise) begin
                        d.restart = 1'b0;
                        d.idx     = '0;
                        d.st      = S_SEND;
                    end else if (nxt_ext >= count) begin
                        d.idx = '0;
                        d.st  = skip ? S_HOLD : S_SEND;
                    end else begin
                        d.idx = nxt_ext[IDX_W-1:0];
                        d.st  = S_SEND;
                    end
                end
            end
            S_HOLD: begin
                if (!run) begin
                    d.st = S_IDLE;
                end else if (rep_tick) begin
                    d.st = S_SEND;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, idx: '0, run_prev: 1'b0, restart: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rd_idx     = q.idx;
    assign start_word = line_order(rd_word, par_en, par_even);
    assign start_slow = slow;

    p_no_start_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> run);

    p_start_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (CNT_W'(rd_idx) < count));

    p_hold_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_HOLD && run && !rep_tick) |=> (q.st == S_HOLD));

    p_rise_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && q.st == S_IDLE) |=> (rd_idx == '0));

endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser #(
    parameter int HALF_HI   = 2,
    parameter int LO_RATIO  = 8,
    parameter int NULL_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] word,
    input  logic        slow,
    output logic        tx_hi,
    output logic        tx_lo,
    output logic        done,
    output logic        busy
);

    localparam int HALF_LO  = HALF_HI * LO_RATIO;
    localparam int N_HALVES = 2 * NULL_BITS;
    localparam int TMR_W    = $clog2(HALF_LO * N_HALVES + 1);
    localparam logic [TMR_W-1:0] HL_HI = TMR_W'(HALF_HI - 1);
    localparam logic [TMR_W-1:0] HL_LO = TMR_W'(HALF_LO - 1);
    localparam logic [TMR_W-1:0] NL_HI = TMR_W'(HALF_HI * N_HALVES - 1);
    localparam logic [TMR_W-1:0] NL_LO = TMR_W'(HALF_LO * N_HALVES - 1);

    typedef struct packed {
        logic             busy;
        logic             in_null;
        logic             slow;
        logic [31:0]      word;
        logic [4:0]       bit_cnt;
        logic             half;
        logic [TMR_W-1:0] tmr;
        logic             hi;
        logic             lo;
        logic             done;
    } ser_t;

    ser_t q, d;
    logic [TMR_W-1:0] half_end;
    logic [TMR_W-1:0] null_end;
    logic [4:0]       nbit;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        half_end = q.slow ? HL_LO : HL_HI;
        null_end = q.slow ? NL_LO : NL_HI;
        nbit     = q.bit_cnt + 5'd1;
        if (!q.busy) begin
            if (start) begin
                d.busy    = 1'b1;
                d.in_null = 1'b0;
                d.slow    = slow;
                d.word    = word;
                d.bit_cnt = '0;
                d.half    = 1'b0;
                d.tmr     = '0;
                d.hi      = word[0];
                d.lo      = ~word[0];
            end
        end else if (q.in_null) begin
            if (q.tmr == null_end) begin
                d.busy    = 1'b0;
                d.in_null = 1'b0;
                d.done    = 1'b1;
                d.tmr     = '0;
            end else begin
                d.tmr = q.tmr + TMR_W'(1);
            end
        end else if (q.tmr == half_end) begin
            d.tmr = '0;
            if (!q.half) begin
                d.half = 1'b1;
                d.hi   = 1'b0;
                d.lo   = 1'b0;
            end else begin
                d.half = 1'b0;
                if (q.bit_cnt == 5'd31) begin
                    d.in_null = 1'b1;
                end else begin
                    d.bit_cnt = nbit;
                    d.hi      = q.word[nbit];
                    d.lo      = ~q.word[nbit];
                end
            end
        end else begin
            d.tmr = q.tmr + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_hi = q.hi;
    assign tx_lo = q.lo;
    assign done  = q.done;
    assign busy  = q.busy;

    p_excl_hilo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_hi && tx_lo));

    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    p_null_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.in_null |-> (!tx_hi && !tx_lo));

    p_rate_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && d.busy) |=> $stable(q.slow));

endmodule

// File: rtl/a429_tx_channel.sv
module a429_tx_channel #(
    parameter int HALF_HI   = 2,
    parameter int LO_RATIO  = 8,
    parameter int NULL_BITS = 4,
    parameter int DEPTH     = 8,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             rep_tick,
    output logic             tx_hi,
    output logic             tx_lo,
    output logic [7:0]       ctrl_rd
);

    logic [7:0]       ctrl;
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      rd_word;
    logic             start;
    logic [31:0]      start_word;
    logic             start_slow;
    logic             ser_done;
    logic             ser_busy;

    a429_tx_regs #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tbl  (wr_tbl),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .ctrl    (ctrl),
        .count   (count),
        .rd_word (rd_word)
    );

    a429_tx_seq #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl[7]),
        .slow       (ctrl[6]),
        .par_en     (ctrl[5]),
        .par_even   (ctrl[4]),
        .skip       (ctrl[3]),
        .count      (count),
        .rd_word    (rd_word),
        .ser_done   (ser_done),
        .rep_tick   (rep_tick),
        .rd_idx     (rd_idx),
        .start      (start),
        .start_word (start_word),
        .start_slow (start_slow)
    );

    a429_tx_ser #(
        .HALF_HI   (HALF_HI),
        .LO_RATIO  (LO_RATIO),
        .NULL_BITS (NULL_BITS)
    ) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (start_word),
        .slow  (start_slow),
        .tx_hi (tx_hi),
        .tx_lo (tx_lo),
        .done  (ser_done),
        .busy  (ser_busy)
    );

    assign ctrl_rd = ctrl;

    p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[7] && !ser_busy) |=> (!tx_hi && !tx_lo));

endmodule

// File: tb/sim_a429_tx_channel.sv
module sim_a429_tx_channel;

    localparam int CLK_PERIOD = 10;
    localparam int HH    = 2;
    localparam int LR    = 8;
    localparam int NB    = 4;
    localparam int DEPTH = 8;
    localparam int MAXW  = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_tbl = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rep_tick = 1'b0;
    logic        tx_hi, tx_lo;
    logic [7:0]  ctrl_rd;

    a429_tx_channel #(.HALF_HI(HH), .LO_RATIO(LR), .NULL_BITS(NB), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_idx(wr_idx),
        .wr_data(wr_data), .rep_tick(rep_tick), .tx_hi(tx_hi), .tx_lo(tx_lo),
        .ctrl_rd(ctrl_rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] tbl [0:DEPTH-1];

    // line decoder state
    logic [31:0] rx_word [0:MAXW-1];
    int          rx_half [0:MAXW-1];
    int          rx_gap  [0:MAXW-1];
    bit          rx_bad  [0:MAXW-1];
    int          rx_cnt = 0;
    int          bit_i = 0;
    int          idle = 100000;
    int          pw = 0;
    int          cur_w = 0;
    int          first_gap = 0;
    bit          cur_bad = 1'b0;
    bit          both_hi = 1'b0;
    logic [31:0] bits = '0;
    logic        ph = 1'b0, pl = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_hi && tx_lo) both_hi = 1'b1;
            if ((tx_hi || tx_lo) && !(ph || pl)) begin
                if (bit_i == 0) first_gap = idle;
                else if (idle != cur_w) cur_bad = 1'b1;
                bits[bit_i] = tx_hi;
                pw = 1;
                idle = 0;
            end else if (tx_hi || tx_lo) begin
                pw++;
            end else begin
                if (ph || pl) begin
                    if (bit_i == 0) begin
                        cur_w = pw;
                        cur_bad = 1'b0;
                    end else if (pw != cur_w) begin
                        cur_bad = 1'b1;
                    end
                    if (bit_i == 31) begin
                        if (rx_cnt < MAXW) begin
                            for (int i = 0; i < 32; i++)
                                rx_word[rx_cnt][i] = (i < 8) ? bits[7-i] : bits[i];
                            rx_half[rx_cnt] = cur_w;
                            rx_gap[rx_cnt]  = first_gap;
                            rx_bad[rx_cnt]  = cur_bad;
                        end
                        rx_cnt++;
                        bit_i = 0;
                    end else begin
                        bit_i++;
                    end
                end
                idle++;
            end
            ph = tx_hi;
            pl = tx_lo;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input bit t, input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = t; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_tbl = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wait until rx_cnt >= n and the word in flight has reached bit k
    task automatic wait_pos(input int n, input int k);
        while (!(rx_cnt > n || (rx_cnt == n && bit_i >= k))) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] data, input logic [7:0] c);
        logic [31:0] w;
        int ones;
        w = data;
        if (c[5]) begin
            w[31] = 1'b0;
            ones = $countones(w);
            w[31] = c[4] ? ((ones % 2) == 1) : ((ones % 2) == 0);
        end
        return w;
    endfunction

    task automatic check_word(input int j, input int e, input logic [7:0] c, input string req);
        int hw;
        hw = c[6] ? HH * LR : HH;
        chk(rx_word[j] == exp_word(tbl[e], c), req, "word content", rx_word[j], exp_word(tbl[e], c));
        chk(rx_half[j] == hw, "R4", "half cell width", rx_half[j], hw);
        chk(!rx_bad[j], "R7", "uniform RZ cells", 32'(rx_bad[j]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        logic [7:0] c;
        for (int i = 0; i < DEPTH; i++) tbl[i] = 32'hA5C3_0F1E ^ (32'(i) * 32'h1357_9BDF);
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1: reset state
        chk(ctrl_rd == 8'h00, "R1", "control reset", 32'(ctrl_rd), 0);
        chk(!tx_hi && !tx_lo, "R7", "idle lines after reset", {30'd0, tx_hi, tx_lo}, 0);

        for (int i = 0; i < DEPTH; i++) wr(1'b1, 3'(i), tbl[i]);
        // R1 / R11: unused bits are storage, no run means no output (R2)
        wr(1'b0, 3'd0, 32'hFFFF_FF07);
        chk(ctrl_rd == 8'h07, "R11", "control readback", 32'(ctrl_rd), 32'h07);
        wr(1'b0, 3'd1, 32'd3);
        wait_cyc(600);
        chk(rx_cnt == 0, "R2", "no words with run clear", rx_cnt, 0);
        wr(1'b0, 3'd0, 32'h0);

        // R4 R5 R9 R3 R2: sweep rate x parity enable x parity sense
        for (int cfg = 0; cfg < 8; cfg++) begin
            c = {1'b1, 3'(cfg), 4'b0000};
            base = rx_cnt;
            wr(1'b0, 3'd0, 32'(c));
            wait_pos(base + 2, 5);
            wr(1'b0, 3'd0, 32'(c & 8'h7F));
            wait_cyc(3000);
            chk(rx_cnt == base + 3, "R2", "stop completes current word only", rx_cnt, base + 3);
            for (int j = 0; j < 3; j++) begin
                check_word(base + j, j, c, (j == 0) ? "R3" : "R5_R9");
                if (j > 0)
                    chk(rx_gap[base+j] >= (c[6] ? HH*LR : HH) * (1 + 2*NB), "R8",
                        "null gap", rx_gap[base+j], (c[6] ? HH*LR : HH) * (1 + 2*NB));
            end
        end

        // R6 immediate restart, R10 wrap at count
        wr(1'b0, 3'd1, 32'd2);
        base = rx_cnt;
        wr(1'b0, 3'd0, 32'h80);
        wait_pos(base + 4, 3);
        wr(1'b0, 3'd0, 32'h00);
        wait_cyc(1500);
        chk(rx_cnt == base + 5, "R10", "words in two and a half passes", rx_cnt, base + 5);
        for (int j = 0; j < 5; j++) check_word(base + j, j % 2, 8'h80, "R10");
        chk(rx_gap[base+2] <= HH * (1 + 2*NB) + 6, "R6", "immediate pass restart gap",
            rx_gap[base+2], HH * (1 + 2*NB) + 6);

        // R3: clear and set run during a word -> that word ends, entry 0 follows
        base = rx_cnt;
        wr(1'b0, 3'd0, 32'h80);
        wait_pos(base + 1, 10);
        wr(1'b0, 3'd0, 32'h00);
        wr(1'b0, 3'd0, 32'h80);
        wait_pos(base + 2, 2);
        wr(1'b0, 3'd0, 32'h00);
        wait_cyc(1500);
        chk(rx_cnt == base + 3, "R2", "word count after toggle", rx_cnt, base + 3);
        check_word(base + 1, 1, 8'h80, "R3");
        check_word(base + 2, 0, 8'h80, "R3");

        // R6: wait-for-tick mode, early tick ignored
        base = rx_cnt;
        wr(1'b0, 3'd0, 32'h88);
        wait_pos(base + 1, 3);
        @(negedge clk); rep_tick = 1'b1; @(negedge clk); rep_tick = 1'b0;
        wait_pos(base + 2, 0);
        wait_cyc(2000);
        chk(rx_cnt == base + 2, "R6", "pass held without tick", rx_cnt, base + 2);
        chk(!tx_hi && !tx_lo, "R6", "lines idle while held", {30'd0, tx_hi, tx_lo}, 0);
        @(negedge clk); rep_tick = 1'b1; @(negedge clk); rep_tick = 1'b0;
        wait_pos(base + 4, 0);
        wait_cyc(1500);
        chk(rx_cnt == base + 4, "R6", "one pass per tick", rx_cnt, base + 4);
        check_word(base + 2, 0, 8'h88, "R6");
        check_word(base + 3, 1, 8'h88, "R6");
        wr(1'b0, 3'd0, 32'h08);
        @(negedge clk); rep_tick = 1'b1; @(negedge clk); rep_tick = 1'b0;
        wait_cyc(1500);
        chk(rx_cnt == base + 4, "R2", "tick ignored when stopped", rx_cnt, base + 4);

        // R4: rate change mid word applies at the next word
        base = rx_cnt;
        wr(1'b0, 3'd0, 32'h80);
        wait_pos(base, 10);
        wr(1'b0, 3'd0, 32'hC0);
        wait_pos(base + 1, 2);
        wr(1'b0, 3'd0, 32'h40);
        wait_cyc(3000);
        chk(rx_cnt == base + 2, "R4", "words around rate change", rx_cnt, base + 2);
        check_word(base, 0, 8'h80, "R4");
        check_word(base + 1, 1, 8'hC0, "R4");

        // R10: zero count sends nothing; oversized count clamps to DEPTH
        wr(1'b0, 3'd1, 32'd0);
        base = rx_cnt;
        wr(1'b0, 3'd0, 32'h80);
        wait_cyc(1500);
        chk(rx_cnt == base, "R10", "zero count sends nothing", rx_cnt, base);
        wr(1'b0, 3'd0, 32'h00);
        wr(1'b0, 3'd1, 32'd12);
        base = rx_cnt;
        wr(1'b0, 3'd0, 32'h88);
        wait_pos(base + DEPTH, 0);
        wait_cyc(2000);
        chk(rx_cnt == base + DEPTH, "R10", "clamped pass length", rx_cnt, base + DEPTH);
        for (int j = 0; j < DEPTH; j++) check_word(base + j, j, 8'h88, "R10");
        wr(1'b0, 3'd0, 32'h00);

        chk(!both_hi, "R7", "HI and LO never together", 32'(both_hi), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule